// File: doc/BRIEF.md
# Buffered SPI Master Transmit Engine

This block is the transmit half of an SPI master. A host loads bytes one at a time through a write strobe into a single holding register. The engine moves each byte into an 8-bit shift register and drives it out on the data line while it generates the serial clock. Because the holding register can take the next byte while the current one is still shifting, a host that keeps up sends any number of frames with no idle clock between them.

Two flags guide the host. The buffer-empty flag (`txe`) shows when another byte may be written. The busy flag (`bsy`) shows that a frame is in flight or that the clock is running. Clock polarity, clock phase, bit order, the line mode and the clock divider are captured only while the engine is disabled. This lets the host set them up and then enable the engine without glitching the line. A receive-only line mode runs the clock continuously and leaves the data line undriven.

Top module: `spi_tx_engine`

## Requirements
- R1: While reset is asserted and after it is released, `txe`=1, `bsy`=0, `ovrErr`=0, `mosi`=0, `sck`=0, and the captured configuration is cpol=0, cpha=0, MSB-first, mode 00, divider 0.
- R2: A write strobe accepted while `txe`=1 clears `txe` on the next edge. `txe` returns to 1 on the edge at which the buffered byte is moved into the shift register.
- R3: A write strobe while `txe`=0 leaves the buffer and the frame stream unchanged and sets `ovrErr`. `ovrErr` stays set until an `errClear` strobe arrives without a rejected write in the same cycle.
- R4: Each frame is 8 bits. `lsbFirst`=0 sends bit 7 first and `lsbFirst`=1 sends bit 0 first. `mosi` is 0 whenever no transmit frame is active.
- R5: One SCK period is 2*(`divVal`+1) clock cycles, and `sck` rests at `cpol` when idle. With `cpha`=0 the first half of each bit sits at the rest level. With `cpha`=1 the first half sits at the opposite level. In both cases `mosi` changes only at bit boundaries.
- R6: A frame starts on the edge after a byte is buffered while the engine is enabled and idle. If the buffer is full when a frame ends, the next frame starts on that same edge, with no gap. `bsy` is high from the first frame until a frame ends with the buffer empty.
- R7: `mode` encodings: 00 = two-line transmit, with `mosiOe` held at 1. 01 = single-line transmit, with `mosiOe` equal to `enable`. 10 and 11 = receive-only: `mosiOe`=0, `mosi`=0, and SCK runs continuously with `bsy`=1 while enabled, even with a byte buffered.
- R8: `cpol`, `cpha`, `lsbFirst`, `mode` and `divVal` are captured on each edge where `enable`=0. Changes to them while `enable`=1 have no effect.
- R9: `enable`=0 aborts any frame on the next edge: `bsy` drops and `sck` returns to rest. A byte waiting in the buffer is kept, and it starts once the engine is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Engine enable; configuration is captured while low |
| cpol | input | 1 | SCK rest level |
| cpha | input | 1 | SCK phase select |
| lsbFirst | input | 1 | 1 = least significant bit first |
| mode | input | 2 | Line mode: 00 two-line, 01 single-line out, 1x receive-only |
| divVal | input | 8 | Half-period of SCK minus one, in clock cycles |
| wrStrobe | input | 1 | Write strobe for the holding buffer |
| wrData | input | 8 | Byte to buffer |
| errClear | input | 1 | Clears the overwrite error flag |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosiOe | output | 1 | Data line output enable |
| txe | output | 1 | Holding buffer empty |
| bsy | output | 1 | Frame in progress or clock running |
| ovrErr | output | 1 | Sticky overwrite error |

## Verification
The engine is driven with four different clock set-ups: both polarities, both phases, both bit orders, and dividers of 0, 1 and 3. With these patterns, an edge-rule error shows up apart from a bit-order error or a period error. Back-to-back runs of three bytes separate the same-edge refill from a refill that costs one cycle. Single-byte frames check that `bsy` drops only when the buffer is empty. A write into the full buffer, a configuration change while enabled, an abort in mid-frame with a byte waiting, and a receive-only run each exercise one of the rules that say what must be ignored or kept.

// File: rtl/spi_tx_pkg.sv
`timescale 1ns/1ps
package spi_tx_pkg;

  typedef enum logic [1:0] {
    LINK_DUAL       = 2'b00,
    LINK_SINGLE_OUT = 2'b01,
    LINK_RX_ONLY    = 2'b10,
    LINK_RX_ALT     = 2'b11
  } linkMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic bufLoad;    // capture host byte into holding register
    logic shiftLoad;  // move holding register into shift register
    logic shiftStep;  // advance shift register by one bit
  } dpStrobes_t;

endpackage

// File: rtl/spi_tx_ctrl.sv
`timescale 1ns/1ps
module spi_tx_ctrl
  import spi_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cpolIn,
  input  logic             cphaIn,
  input  logic             lsbIn,
  input  logic [1:0]       modeIn,
  input  logic [DIV_W-1:0] divIn,
  input  logic             wrStrobe,
  input  logic             errClear,
  output dpStrobes_t       strobes,
  output logic             cfgCpol,
  output logic             cfgCpha,
  output logic             cfgLsb,
  output linkMode_e        cfgMode,
  output logic             running,
  output logic             phaseOdd,
  output logic             txe,
  output logic             ovrErr
);

  localparam int HALF_N = 2 * DATA_W;
  localparam int HALF_W = $clog2(HALF_N);
  localparam logic [HALF_W-1:0] LAST_HALF = HALF_W'(HALF_N - 1);

  logic [DIV_W-1:0]  cfgDiv;
  logic [DIV_W-1:0]  divCnt;
  logic [HALF_W-1:0] halfCnt;
  logic              runR;
  logic              txeR;
  logic              errR;

  logic rxMode;
  logic tick;
  logic lastHalf;
  logic frameEnd;
  logic wrAccept;
  logic wrReject;
  logic startLoad;
  logic chainLoad;
  logic runNext;

  // configuration shadow: follows inputs only while disabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgCpol <= 1'b0;
      cfgCpha <= 1'b0;
      cfgLsb  <= 1'b0;
      cfgMode <= LINK_DUAL;
      cfgDiv  <= '0;
    end else if (!enable) begin
      cfgCpol <= cpolIn;
      cfgCpha <= cphaIn;
      cfgLsb  <= lsbIn;
      cfgMode <= linkMode_e'(modeIn);
      cfgDiv  <= divIn;
    end
  end

  always_comb begin
    rxMode    = cfgMode[1];
    tick      = runR && (divCnt == cfgDiv);
    lastHalf  = (halfCnt == LAST_HALF);
    frameEnd  = tick && lastHalf;
    wrAccept  = wrStrobe && txeR;
    wrReject  = wrStrobe && !txeR;
    startLoad = enable && !rxMode && !runR && !txeR;
    chainLoad = enable && !rxMode && frameEnd && !txeR;

    strobes.bufLoad   = wrAccept;
    strobes.shiftLoad = startLoad || chainLoad;
    strobes.shiftStep = tick && halfCnt[0];

    if (!enable)
      runNext = 1'b0;
    else if (rxMode)
      runNext = 1'b1;
    else if (startLoad)
      runNext = 1'b1;
    else if (frameEnd && !chainLoad)
      runNext = 1'b0;
    else
      runNext = runR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runR    <= 1'b0;
      divCnt  <= '0;
      halfCnt <= '0;
    end else begin
      runR <= runNext;
      if (!enable || !runR) begin
        divCnt  <= '0;
        halfCnt <= '0;
      end else if (tick) begin
        divCnt  <= '0;
        halfCnt <= lastHalf ? '0 : halfCnt + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txeR <= 1'b1;
      errR <= 1'b0;
    end else begin
      if (wrAccept)
        txeR <= 1'b0;
      else if (startLoad || chainLoad)
        txeR <= 1'b1;

      if (wrReject)
        errR <= 1'b1;
      else if (errClear)
        errR <= 1'b0;
    end
  end

  assign running  = runR;
  assign phaseOdd = halfCnt[0];
  assign txe      = txeR;
  assign ovrErr   = errR;

endmodule

// File: rtl/spi_tx_datapath.sv
`timescale 1ns/1ps
module spi_tx_datapath
  import spi_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic              lsbFirst,
  input  logic [DATA_W-1:0] wrData,
  output logic              mosiBit
);

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] holdRev;

  // bit-reversed copy so the shifter always emits from its top bit
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign holdRev[i] = holdReg[DATA_W-1-i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      holdReg <= '0;
    else if (strobes.bufLoad)
      holdReg <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      shiftReg <= '0;
    else if (strobes.shiftLoad)
      shiftReg <= lsbFirst ? holdRev : holdReg;
    else if (strobes.shiftStep)
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
  end

  assign mosiBit = shiftReg[DATA_W-1];

endmodule

// File: rtl/spi_tx_engine.sv
`timescale 1ns/1ps
module spi_tx_engine
  import spi_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsbFirst,
  input  logic [1:0]        mode,
  input  logic [DIV_W-1:0]  divVal,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              errClear,
  output logic              sck,
  output logic              mosi,
  output logic              mosiOe,
  output logic              txe,
  output logic              bsy,
  output logic              ovrErr
);

  dpStrobes_t strobes;
  logic       cfgCpol;
  logic       cfgCpha;
  logic       cfgLsb;
  linkMode_e  cfgMode;
  logic       running;
  logic       phaseOdd;
  logic       mosiBit;

  spi_tx_ctrl #(
    .DATA_W(DATA_W),
    .DIV_W (DIV_W)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .cpolIn  (cpol),
    .cphaIn  (cpha),
    .lsbIn   (lsbFirst),
    .modeIn  (mode),
    .divIn   (divVal),
    .wrStrobe(wrStrobe),
    .errClear(errClear),
    .strobes (strobes),
    .cfgCpol (cfgCpol),
    .cfgCpha (cfgCpha),
    .cfgLsb  (cfgLsb),
    .cfgMode (cfgMode),
    .running (running),
    .phaseOdd(phaseOdd),
    .txe     (txe),
    .ovrErr  (ovrErr)
  );

  spi_tx_datapath #(
    .DATA_W(DATA_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .lsbFirst(cfgLsb),
    .wrData  (wrData),
    .mosiBit (mosiBit)
  );

  always_comb begin
    sck  = running ? (cfgCpol ^ cfgCpha ^ phaseOdd) : cfgCpol;
    mosi = (running && !cfgMode[1]) ? mosiBit : 1'b0;
    unique case (cfgMode)
      LINK_DUAL:       mosiOe = 1'b1;
      LINK_SINGLE_OUT: mosiOe = enable;
      default:         mosiOe = 1'b0;
    endcase
  end

  assign bsy = running;

endmodule

// File: rtl/spi_tx_engine_chk.sv
`timescale 1ns/1ps
module spi_tx_engine_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic wrStrobe,
  input logic errClear,
  input logic sck,
  input logic mosi,
  input logic txe,
  input logic bsy,
  input logic ovrErr
);

  a_r3_reject_sets_err: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !txe) |=> ovrErr);

  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovrErr && !errClear) |=> ovrErr);

  a_r2_txe_falls_on_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txe) |-> $past(wrStrobe));

  a_r6_idle_only_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(bsy) && $past(enable)) |-> $past(txe));

  a_r9_disable_drops_bsy: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !bsy);

  a_r5_idle_sck_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!bsy && $past(!bsy) && enable && $past(enable)) |-> $stable(sck));

  a_r4_idle_mosi_low: assert property (@(posedge clk) disable iff (!rstN)
    !bsy |-> !mosi);

endmodule

bind spi_tx_engine spi_tx_engine_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .enable  (enable),
  .wrStrobe(wrStrobe),
  .errClear(errClear),
  .sck     (sck),
  .mosi    (mosi),
  .txe     (txe),
  .bsy     (bsy),
  .ovrErr  (ovrErr)
);

// File: tb/spi_tx_engine_tb_top.sv
`timescale 1ns/1ps
module spi_tx_engine_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       enable;
  logic       cpol, cpha, lsbFirst;
  logic [1:0] mode;
  logic [7:0] divVal;
  logic       wrStrobe;
  logic [7:0] wrData;
  logic       errClear;
  logic       sck, mosi, mosiOe, txe, bsy, ovrErr;

  always #4 clk = ~clk;  // 125 MHz

  spi_tx_engine dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .cpol(cpol), .cpha(cpha),
    .lsbFirst(lsbFirst), .mode(mode), .divVal(divVal), .wrStrobe(wrStrobe),
    .wrData(wrData), .errClear(errClear), .sck(sck), .mosi(mosi),
    .mosiOe(mosiOe), .txe(txe), .bsy(bsy), .ovrErr(ovrErr)
  );

  int vecCnt  = 0;
  int failCnt = 0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] mQ[$];
  logic [7:0] mCur;
  bit         mRun, mTxe, mErr, mStarted;
  int         mCyc;
  bit         mCpol, mCpha, mLsb;
  logic [1:0] mMode;
  int         mDiv;

  always @(posedge clk) begin
    bit oldTxe, oldFull;
    int total;
    mStarted = 1;
    if (!rstN) begin
      mQ.delete();
      mCur = 8'h00; mRun = 0; mTxe = 1; mErr = 0; mCyc = 0;
      mCpol = 0; mCpha = 0; mLsb = 0; mMode = 2'b00; mDiv = 0;
    end else begin
      oldTxe  = mTxe;
      oldFull = (mQ.size() > 0);
      total   = 16 * (mDiv + 1);
      if (!enable) begin
        mRun = 0; mCyc = 0;
      end else if (mMode[1]) begin
        if (!mRun) begin mRun = 1; mCyc = 0; end
        else mCyc = (mCyc + 1) % total;
      end else if (mRun) begin
        if (mCyc == total - 1) begin
          if (oldFull) begin mCur = mQ.pop_front(); mCyc = 0; mTxe = 1; end
          else begin mRun = 0; mCyc = 0; end
        end else mCyc++;
      end else if (oldFull) begin
        mCur = mQ.pop_front(); mRun = 1; mCyc = 0; mTxe = 1;
      end
      if (wrStrobe && oldTxe) begin mQ.push_back(wrData); mTxe = 0; end
      if (wrStrobe && !oldTxe) mErr = 1;
      else if (errClear) mErr = 0;
      if (!enable) begin
        mCpol = cpol; mCpha = cpha; mLsb = lsbFirst; mMode = mode; mDiv = int'(divVal);
      end
    end
  end

  always @(negedge clk) begin
    int  half, idx;
    bit  eSck, eMosi, eOe;
    if (mStarted) begin
      half = mCyc / (mDiv + 1);
      idx  = half / 2;
      eSck  = mRun ? (mCpol ^ mCpha ^ half[0]) : mCpol;
      eMosi = (mRun && !mMode[1]) ? (mLsb ? mCur[idx] : mCur[7-idx]) : 1'b0;
      eOe   = (mMode == 2'b00) ? 1'b1 : (mMode == 2'b01) ? enable : 1'b0;
      chk("R5 sck", 32'(sck), 32'(eSck));
      chk("R4 mosi", 32'(mosi), 32'(eMosi));
      chk("R7 mosiOe", 32'(mosiOe), 32'(eOe));
      chk("R2 txe", 32'(txe), 32'(mTxe));
      chk("R6 bsy", 32'(bsy), 32'(mRun));
      chk("R3 ovrErr", 32'(ovrErr), 32'(mErr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setCfg(input bit p, input bit h, input bit l, input logic [1:0] m, input logic [7:0] d);
    cpol = p; cpha = h; lsbFirst = l; mode = m; divVal = d;
  endtask

  task automatic writeByte(input logic [7:0] b);
    while (txe !== 1'b1) tick(1);
    wrStrobe = 1'b1; wrData = b;
    tick(1);
    wrStrobe = 1'b0;
  endtask

  task automatic rawWrite(input logic [7:0] b);
    wrStrobe = 1'b1; wrData = b;
    tick(1);
    wrStrobe = 1'b0;
  endtask

  task automatic waitIdle();
    do tick(1); while (!(txe === 1'b1 && bsy === 1'b0));
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; wrStrobe = 1'b0; wrData = 8'h00; errClear = 1'b0;
    setCfg(0, 0, 0, 2'b00, 8'd0);
    tick(4);
    // R1: reset state
    chk("R1 txe", 32'(txe), 32'd1);
    chk("R1 bsy", 32'(bsy), 32'd0);
    chk("R1 ovrErr", 32'(ovrErr), 32'd0);
    chk("R1 sck", 32'(sck), 32'd0);
    chk("R1 mosi", 32'(mosi), 32'd0);
    rstN = 1'b1;
    tick(2);
    chk("R7 two-line oe while disabled", 32'(mosiOe), 32'd1);

    // two-line, cpol0 cpha0, div0, MSB first, back-to-back
    enable = 1'b1;
    tick(1);
    writeByte(8'hF1);
    writeByte(8'hF2);
    rawWrite(8'hAA);  // R3: buffer full, must be dropped
    chk("R3 overwrite flagged", 32'(ovrErr), 32'd1);
    chk("R3 buffer still holds earlier byte", 32'(txe), 32'd0);
    errClear = 1'b1; tick(1); errClear = 1'b0;
    chk("R3 cleared", 32'(ovrErr), 32'd0);
    writeByte(8'hF3);
    waitIdle();
    chk("R6 bsy low after last frame", 32'(bsy), 32'd0);
    enable = 1'b0;
    tick(1);

    // single-line, cpol1 cpha1, div1, LSB first
    setCfg(1, 1, 1, 2'b01, 8'd1);
    tick(1);
    enable = 1'b1;
    tick(1);
    chk("R7 single-line oe enabled", 32'(mosiOe), 32'd1);
    writeByte(8'hC5);
    writeByte(8'h3A);
    waitIdle();
    enable = 1'b0;
    tick(1);
    chk("R7 single-line oe released", 32'(mosiOe), 32'd0);

    // R8: config change while enabled has no effect
    setCfg(1, 0, 0, 2'b00, 8'd3);
    tick(1);
    enable = 1'b1;
    tick(2);
    cpol = 1'b0; divVal = 8'd0; lsbFirst = 1'b1;
    tick(3);
    chk("R8 sck rest kept", 32'(sck), 32'd1);
    writeByte(8'h96);
    waitIdle();
    enable = 1'b0;
    tick(1);

    // R9: abort mid-frame, buffered byte kept
    setCfg(0, 1, 0, 2'b00, 8'd1);
    tick(1);
    enable = 1'b1;
    writeByte(8'h5A);
    tick(20);
    enable = 1'b0;
    tick(1);
    chk("R9 bsy dropped", 32'(bsy), 32'd0);
    chk("R9 sck at rest", 32'(sck), 32'd0);
    writeByte(8'h33);
    tick(2);
    chk("R9 byte held while disabled", 32'(txe), 32'd0);
    enable = 1'b1;
    tick(2);
    chk("R9 held byte starts", 32'(bsy), 32'd1);
    waitIdle();
    enable = 1'b0;
    tick(1);

    // R7: receive-only clock generation
    setCfg(0, 0, 0, 2'b10, 8'd0);
    tick(1);
    enable = 1'b1;
    writeByte(8'h77);
    tick(40);
    chk("R7 rx bsy", 32'(bsy), 32'd1);
    chk("R7 rx oe", 32'(mosiOe), 32'd0);
    chk("R7 rx mosi", 32'(mosi), 32'd0);
    chk("R7 rx byte not taken", 32'(txe), 32'd0);
    enable = 1'b0;
    tick(1);
    chk("R7 rx stop", 32'(bsy), 32'd0);
    tick(2);
    finishRun();
  end

endmodule